// File: doc/BRIEF.md
# Selectable Watchdog Timer

This block watches a kick line, which the system shares with a serial chip select, and raises a one-cycle expiry request when that line has shown no high-to-low transition for the selected timeout. The timeout is measured in ticks of a slow timebase strobe. A 2-bit setting picks one of three timeout lengths, and a fourth code turns the watchdog off. The setting comes in as an input, so whatever stores it lives outside this block.

The kick line is asynchronous. It passes through a two-flop synchronizer, and edge detection works on the synchronized value. A steady level, high or low, never restarts the count. Only a falling edge does. The hold input is asserted while the system is in reset. It clears the block, so a full timeout starts once reset is released. A change of setting also restarts the count.

Top module: `kick_watchdog`

## Requirements
- R1: With the kick line steady, `expire` pulses after exactly TICKS_LONG ticks for setting 2'b00, TICKS_MID ticks for 2'b01 and TICKS_SHORT ticks for 2'b10, all counted from the last restart. The defaults are 1400, 600 and 200.
- R2: Setting 2'b11 turns the watchdog off, and `expire` stays low for as long as that setting is applied.
- R3: A high-to-low transition on `kick_in` restarts the count. A change driven before clock edge j clears the counter at edge j+2, which is two synchronizer flops plus one edge-detect flop.
- R4: A rising edge on `kick_in`, or a level held high or low, does not restart the count. If the line stays stuck, the expiry repeats once per timeout.
- R5: A low pulse on `kick_in` lasting two clock periods or more is seen as a falling edge and restarts the count.
- R6: While `hold` is high, the counter stays at zero and `expire` stays low. The clock edge on which `hold` is last high counts as the restart.
- R7: When `sel` changes value, the count restarts on the first clock edge that sees the new value, and the new timeout then applies.
- R8: `expire` is a registered pulse one clock long. After each expiry the count begins again from zero.
- R9: The count advances only on cycles with `tick` high, and an expiry follows only a cycle with `tick` high.
- R10: During and right after reset (`hold` high), `expire` reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| hold | input | 1 | Synchronous active-high clear, asserted while system reset is held |
| kick_in | input | 1 | Asynchronous kick line; a falling edge restarts the count |
| tick | input | 1 | One-cycle timebase strobe |
| sel | input | 2 | Timeout setting: 00 long, 01 mid, 10 short, 11 off |
| expire | output | 1 | One-cycle expiry request |

## Verification
The bench builds the block with timeouts of 14, 6 and 3 ticks and drives `tick` on every cycle. With these values, several consecutive expiries for each setting fit in a few dozen cycles. The same short windows cover restarts caused by a kick edge, a change of setting or a hold, and in each case the bench checks the exact expiry cycle that it computes from the synchronizer latency. A run with ticks on alternate cycles checks that only tick cycles are counted.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  typedef enum logic [1:0] {
    SEL_LONG  = 2'b00,
    SEL_MID   = 2'b01,
    SEL_SHORT = 2'b10,
    SEL_OFF   = 2'b11
  } wdt_sel_e;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    return m;
  endfunction
endpackage

// File: rtl/wdt_kick_sync.sv
module wdt_kick_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic kick_in,
  output logic kick_fall
);
  localparam int W = STAGES + 1;

  logic [W-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[W-2:0], kick_in};
  end

  // chain[W-2] is the last synchronized sample; chain[W-1] is one cycle older
  assign kick_fall = chain[W-1] & ~chain[W-2];

  // R5: a detected edge lasts exactly one cycle
  assert_fall_single_R5: assert property (@(posedge clk) disable iff (rst)
    kick_fall |=> !kick_fall);
endmodule

// File: rtl/wdt_period_sel.sv
module wdt_period_sel
  import wdt_pkg::*;
#(
  parameter int TICKS_LONG  = 1400,
  parameter int TICKS_MID   = 600,
  parameter int TICKS_SHORT = 200,
  parameter int CW          = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    sel,
  output logic [CW-1:0] last_cnt,
  output logic          off,
  output logic          sel_change
);
  logic [1:0] sel_q;

  always_ff @(posedge clk) begin
    if (rst) sel_q <= sel;
    else     sel_q <= sel;
  end

  assign sel_change = (sel != sel_q);
  assign off        = (sel == SEL_OFF);

  always_comb begin
    unique case (sel)
      SEL_LONG:  last_cnt = CW'(TICKS_LONG - 1);
      SEL_MID:   last_cnt = CW'(TICKS_MID - 1);
      SEL_SHORT: last_cnt = CW'(TICKS_SHORT - 1);
      default:   last_cnt = '0;
    endcase
  end
endmodule

// File: rtl/wdt_tick_counter.sv
module wdt_tick_counter #(
  parameter int CW   = 11,
  parameter int TMAX = 1400
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          restart,
  input  logic          tick,
  input  logic [CW-1:0] last_cnt,
  output logic          expire
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      expire <= 1'b0;
    end else begin
      expire <= 1'b0;
      if (restart) begin
        cnt <= '0;
      end else if (tick) begin
        if (cnt == last_cnt) begin
          cnt    <= '0;
          expire <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  assert_pulse_single_R8: assert property (@(posedge clk) disable iff (rst)
    expire |=> !expire);

  assert_tick_gated_R9: assert property (@(posedge clk) disable iff (rst)
    expire |-> $past(tick));

  assert_restart_clears_R3: assert property (@(posedge clk) disable iff (rst)
    restart |=> (cnt == '0 && !expire));

  assert_cnt_range_R1: assert property (@(posedge clk) disable iff (rst)
    int'(cnt) < TMAX);
endmodule

// File: rtl/kick_watchdog.sv
module kick_watchdog
  import wdt_pkg::*;
#(
  parameter int TICKS_LONG  = 1400,
  parameter int TICKS_MID   = 600,
  parameter int TICKS_SHORT = 200,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       hold,
  input  logic       kick_in,
  input  logic       tick,
  input  logic [1:0] sel,
  output logic       expire
);
  localparam int TMAX = max3(TICKS_LONG, TICKS_MID, TICKS_SHORT);
  localparam int CW   = $clog2(TMAX + 1);

  logic          kick_fall;
  logic          off;
  logic          sel_change;
  logic [CW-1:0] last_cnt;
  logic          restart;

  wdt_kick_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst       (hold),
    .kick_in   (kick_in),
    .kick_fall (kick_fall)
  );

  wdt_period_sel #(
    .TICKS_LONG (TICKS_LONG),
    .TICKS_MID  (TICKS_MID),
    .TICKS_SHORT(TICKS_SHORT),
    .CW         (CW)
  ) u_sel (
    .clk        (clk),
    .rst        (hold),
    .sel        (sel),
    .last_cnt   (last_cnt),
    .off        (off),
    .sel_change (sel_change)
  );

  assign restart = kick_fall | sel_change | off;

  wdt_tick_counter #(.CW(CW), .TMAX(TMAX)) u_cnt (
    .clk      (clk),
    .rst      (hold),
    .restart  (restart),
    .tick     (tick),
    .last_cnt (last_cnt),
    .expire   (expire)
  );

  assert_off_silent_R2: assert property (@(posedge clk) disable iff (hold)
    (sel == SEL_OFF) |=> !expire);

  assert_hold_quiet_R6: assert property (@(posedge clk)
    hold |=> !expire);
endmodule

// File: tb/kick_watchdog_bench.sv
module kick_watchdog_bench;
  localparam int L0 = 14;
  localparam int L1 = 6;
  localparam int L2 = 3;

  logic       clk = 1'b0;
  logic       hold = 1'b1;
  logic       kick_in = 1'b1;
  logic       tick = 1'b1;
  logic [1:0] sel = 2'b00;
  logic       expire;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  int doubles = 0;

  always #2.5 clk = ~clk;

  kick_watchdog #(.TICKS_LONG(L0), .TICKS_MID(L1), .TICKS_SHORT(L2)) u_kick_watchdog (
    .clk(clk), .hold(hold), .kick_in(kick_in), .tick(tick), .sel(sel), .expire(expire)
  );

  always @(posedge clk) cycles <= cycles + 1;

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Holds the block with the given setting and kick level, then runs n cycles.
  // Index i is the clock edge i after release; edge 0 is the last hold edge.
  task automatic run(input int n, input logic [1:0] sel0, input logic kick0,
                     input int fall_at, input int rise_at,
                     input int sel_at, input logic [1:0] sel_new,
                     input int hold_on, input int hold_off, input bit sparse,
                     output int first, output int hits, output int hold_hits);
    logic prev;
    hold = 1'b1; sel = sel0; kick_in = kick0; tick = 1'b1;
    repeat (3) begin @(posedge clk); @(negedge clk); end
    first = 0; hits = 0; hold_hits = 0; prev = 1'b0;
    for (int i = 1; i <= n; i++) begin
      if (i == fall_at) kick_in = 1'b0;
      if (i == rise_at) kick_in = 1'b1;
      if (i == sel_at)  sel = sel_new;
      hold = (i >= hold_on && i < hold_off);
      tick = sparse ? ((i % 2) == 1) : 1'b1;
      @(posedge clk); @(negedge clk);
      if (expire) begin
        hits++;
        if (first == 0) first = i;
        if (hold) hold_hits++;
        if (prev) doubles++;
      end
      prev = expire;
    end
  endtask

  initial begin
    int f, h, hh;
    // R10: reset state
    repeat (4) begin @(posedge clk); @(negedge clk); end
    check("R10 expire during hold", int'(expire), 0);

    // R1 / R4 / R8: stuck high, each setting, repeated expiry
    run(3*L0+1, 2'b00, 1'b1, -1, -1, -1, 2'b00, -1, -1, 1'b0, f, h, hh);
    check("R1 long first", f, L0);
    check("R4 long repeats", h, 3);
    run(3*L1+1, 2'b01, 1'b1, -1, -1, -1, 2'b00, -1, -1, 1'b0, f, h, hh);
    check("R1 mid first", f, L1);
    check("R4 mid repeats", h, 3);
    run(3*L2+1, 2'b10, 1'b1, -1, -1, -1, 2'b00, -1, -1, 1'b0, f, h, hh);
    check("R1 short first", f, L2);
    check("R8 short repeats", h, 3);

    // R2: off code
    run(40, 2'b11, 1'b1, -1, -1, -1, 2'b00, -1, -1, 1'b0, f, h, hh);
    check("R2 off no expiry", h, 0);

    // R4: stuck low
    run(L1+1, 2'b01, 1'b0, -1, -1, -1, 2'b00, -1, -1, 1'b0, f, h, hh);
    check("R4 stuck low first", f, L1);

    // R3: falling edge at 3 -> restart at edge 5
    run(25, 2'b00, 1'b1, 3, -1, -1, 2'b00, -1, -1, 1'b0, f, h, hh);
    check("R3 kick fall first", f, 3 + 2 + L0);
    check("R3 kick fall hits", h, 1);

    // R4: rising edge does not restart
    run(L1+1, 2'b01, 1'b0, -1, 3, -1, 2'b00, -1, -1, 1'b0, f, h, hh);
    check("R4 rise ignored", f, L1);

    // R5: two-cycle low pulse
    run(14, 2'b01, 1'b1, 4, 6, -1, 2'b00, -1, -1, 1'b0, f, h, hh);
    check("R5 short pulse", f, 4 + 2 + L1);

    // R7: setting change at 5 to short
    run(20, 2'b00, 1'b1, -1, -1, 5, 2'b10, -1, -1, 1'b0, f, h, hh);
    check("R7 sel change", f, 5 + L2);

    // R6: hold for edges 3..8
    run(16, 2'b01, 1'b1, -1, -1, -1, 2'b00, 3, 9, 1'b0, f, h, hh);
    check("R6 hold restart", f, 8 + L1);
    check("R6 quiet in hold", hh, 0);

    // R9: ticks on odd edges only
    run(8, 2'b10, 1'b1, -1, -1, -1, 2'b00, -1, -1, 1'b1, f, h, hh);
    check("R9 sparse ticks", f, 2*L2 - 1);

    check("R8 no back-to-back", doubles, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    wait (cycles > 20000);
    total++;
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule